// File: doc/BRIEF.md
# Composite Video Sync Sequencer

This block produces the timing skeleton of a progressive PAL-style composite frame from a single 24 MHz clock. A frame is a counted sequence of slots. First comes a group of broad vertical-sync half-lines, each with a long low pulse. Next comes a group of narrow equalising half-lines, each with a short low pulse. A single picture phase follows, made of full-length lines. Each of these lines carries its own line-sync pulse, a back porch, an active region and a front porch. A trailing group of narrow half-lines closes the frame, and the sequence then wraps to the first broad slot.

The active-low sync output and the other outputs are registered. They change only on segment boundaries. A one-cycle trigger marks the start of every frame, for an oscilloscope or a frame-rate consumer. During the picture phase an active-video flag and a zero-based line index tell a downstream pixel shifter when to emit data and which row to fetch. Every duration and count is a parameter. If the state counter ever holds a value outside the frame, it returns to the first broad slot.

Top module: `comp_sync_seq`

## Requirements
- R1: While `rst` is high (synchronous), `sync_n` is 1, `frame_trig` is 0, `active` is 0 and `line_idx` is 0. The first output position after reset release is frame position 0, which appears on the outputs one clock after the first rising edge with `rst` low.
- R2: Each broad slot lasts SLOT_CYC cycles. `sync_n` is 0 for the first SLOT_CYC-SEG_CYC cycles of the slot and 1 for the last SEG_CYC cycles.
- R3: Each narrow slot lasts SLOT_CYC cycles. `sync_n` is 0 for the first SEG_CYC cycles of the slot and 1 for the rest.
- R4: A frame is N_LONG broad slots, then N_PRE narrow slots, then the picture phase, then N_POST narrow slots. After the last narrow slot the next cycle is the first broad slot of a new frame.
- R5: The picture phase is N_LINES consecutive lines of LINE_CYC cycles each. Each line starts with HSYNC_CYC cycles of `sync_n` = 0, and `sync_n` is 1 for the rest of the line.
- R6: Within a picture line, `active` is 1 from cycle HSYNC_CYC+BPORCH_CYC up to and including cycle LINE_CYC-FPORCH_CYC-1, and 0 at every other time. `sync_n` is 1 whenever `active` is 1.
- R7: `line_idx` equals the zero-based number of the current picture line during the picture phase, and 0 outside it.
- R8: `frame_trig` is 1 for exactly one cycle per frame: the first cycle of the first broad slot.
- R9: The cycle after the last cycle of the last picture line is the first cycle of a narrow slot, with `sync_n` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-timing clock (24 MHz with the default counts) |
| rst | input | 1 | Synchronous reset, active high |
| sync_n | output | 1 | Composite sync, low while a sync pulse is active |
| frame_trig | output | 1 | One-cycle pulse at the start of each frame |
| active | output | 1 | High during the visible part of a picture line |
| line_idx | output | $clog2(N_LINES) | Zero-based picture line number, 0 outside the picture phase |

## Verification
The bench builds the block with scaled-down counts: 2-cycle segments in an 8-cycle slot, 16-cycle lines, two broad slots, two leading narrow slots, three picture lines and three trailing narrow slots. A whole frame is then 104 cycles. At this size the frame wrap, the exit from the picture phase into trailing equalisation, the line-index increments and the porch edges all fall within a few hundred cycles. Every cycle of more than two frames is compared against a position-based model built from the requirements, and a mid-frame reset checks the restart.

// File: rtl/cs_pkg.sv
package cs_pkg;
   typedef enum logic [1:0] {
      K_BROAD = 2'd0,
      K_NARROW = 2'd1,
      K_PICTURE = 2'd2
   } slot_kind_t;
endpackage

// File: rtl/cs_slot_timer.sv
module cs_slot_timer
   import cs_pkg::*;
#(
   parameter int SLOT_CYC = 768,
   parameter int LINE_CYC = 1536,
   parameter int CNT_W    = 11
) (
   input  logic             clk,
   input  logic             rst,
   input  slot_kind_t       kind,
   output logic [CNT_W-1:0] cnt,
   output logic             seg_end
);
   logic [CNT_W-1:0] last_cnt;

   always_comb begin
      if (kind == K_PICTURE) last_cnt = CNT_W'(LINE_CYC - 1);
      else                   last_cnt = CNT_W'(SLOT_CYC - 1);
   end

   assign seg_end = (cnt == last_cnt);

   always_ff @(posedge clk) begin
      if (rst)          cnt <= '0;
      else if (seg_end) cnt <= '0;
      else              cnt <= cnt + 1'b1;
   end

   // half-line slots never run past their length (R2, R3)
   p_slot_len_r2: assert property (@(posedge clk) disable iff (rst)
      (kind != K_PICTURE) |-> (cnt < CNT_W'(SLOT_CYC)));

   // a counter wrap always lands on zero (R5)
   p_cnt_restart_r5: assert property (@(posedge clk) disable iff (rst)
      seg_end |=> (cnt == '0));
endmodule

// File: rtl/cs_state_seq.sv
module cs_state_seq
   import cs_pkg::*;
#(
   parameter int N_LONG  = 10,
   parameter int N_PRE   = 10,
   parameter int N_LINES = 304,
   parameter int N_POST  = 12,
   parameter int LINE_W  = 9
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              seg_end,
   output slot_kind_t        kind,
   output logic              frame_head,
   output logic [LINE_W-1:0] line
);
   localparam int TOTAL   = N_LONG + N_PRE + 1 + N_POST;
   localparam int PIC_ST  = N_LONG + N_PRE;
   localparam int STATE_W = $clog2(TOTAL + 1);

   logic [STATE_W-1:0] state;
   logic               bad_state;
   logic               last_line;

   assign bad_state = (state >= STATE_W'(TOTAL));
   assign last_line = (line == LINE_W'(N_LINES - 1));

   always_comb begin
      if (state < STATE_W'(N_LONG))       kind = K_BROAD;
      else if (state == STATE_W'(PIC_ST)) kind = K_PICTURE;
      else                                kind = K_NARROW;
   end

   assign frame_head = (state == '0);

   always_ff @(posedge clk) begin
      if (rst || bad_state) begin
         state <= '0;
         line  <= '0;
      end else if (seg_end) begin
         if (kind == K_PICTURE && !last_line) begin
            line <= line + 1'b1;
         end else begin
            line <= '0;
            if (state == STATE_W'(TOTAL - 1)) state <= '0;
            else                              state <= state + 1'b1;
         end
      end
   end

   // the frame wraps to the first broad slot (R4)
   p_frame_wrap_r4: assert property (@(posedge clk) disable iff (rst)
      (seg_end && state == STATE_W'(TOTAL - 1)) |=> (state == '0));

   // the state stays inside the frame (R4)
   p_state_range_r4: assert property (@(posedge clk) disable iff (rst)
      state < STATE_W'(TOTAL));

   // the last picture line hands over to a narrow slot (R9)
   p_pic_exit_r9: assert property (@(posedge clk) disable iff (rst)
      (seg_end && kind == K_PICTURE && last_line) |=>
         (kind == K_NARROW && line == '0));

   // the line index rests at zero outside the picture (R7)
   p_line_idle_r7: assert property (@(posedge clk) disable iff (rst)
      (kind != K_PICTURE) |-> (line == '0));
endmodule

// File: rtl/cs_wave_gen.sv
module cs_wave_gen
   import cs_pkg::*;
#(
   parameter int SEG_CYC    = 48,
   parameter int SLOT_CYC   = 768,
   parameter int LINE_CYC   = 1536,
   parameter int HSYNC_CYC  = 113,
   parameter int BPORCH_CYC = 137,
   parameter int FPORCH_CYC = 38,
   parameter int CNT_W      = 11,
   parameter int LINE_W     = 9
) (
   input  logic              clk,
   input  logic              rst,
   input  slot_kind_t        kind,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              frame_head,
   input  logic [LINE_W-1:0] line,
   output logic              sync_n_q,
   output logic              trig_q,
   output logic              active_q,
   output logic [LINE_W-1:0] line_q
);
   localparam int ACT_START = HSYNC_CYC + BPORCH_CYC;
   localparam int ACT_STOP  = LINE_CYC - FPORCH_CYC;

   logic sync_low;
   logic vis;

   always_comb begin
      sync_low = 1'b0;
      vis      = 1'b0;
      unique case (kind)
         K_BROAD:   sync_low = (cnt < CNT_W'(SLOT_CYC - SEG_CYC));
         K_NARROW:  sync_low = (cnt < CNT_W'(SEG_CYC));
         K_PICTURE: begin
            sync_low = (cnt < CNT_W'(HSYNC_CYC));
            vis      = (cnt >= CNT_W'(ACT_START)) && (cnt < CNT_W'(ACT_STOP));
         end
         default: begin
            sync_low = 1'b0;
            vis      = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sync_n_q <= 1'b1;
         trig_q   <= 1'b0;
         active_q <= 1'b0;
         line_q   <= '0;
      end else begin
         sync_n_q <= ~sync_low;
         trig_q   <= frame_head && (cnt == '0);
         active_q <= vis;
         line_q   <= line;
      end
   end

   // no sync pulse overlaps visible video (R6)
   p_active_sync_high_r6: assert property (@(posedge clk) disable iff (rst)
      active_q |-> sync_n_q);

   // the frame trigger is a single-cycle pulse (R8)
   p_trig_single_r8: assert property (@(posedge clk) disable iff (rst)
      trig_q |=> !trig_q);

   // a frame starts inside a broad sync pulse (R8)
   p_trig_in_sync_r8: assert property (@(posedge clk) disable iff (rst)
      trig_q |-> !sync_n_q);
endmodule

// File: rtl/comp_sync_seq.sv
module comp_sync_seq
   import cs_pkg::*;
#(
   parameter int SEG_CYC    = 48,
   parameter int SLOT_CYC   = 768,
   parameter int LINE_CYC   = 1536,
   parameter int HSYNC_CYC  = 113,
   parameter int BPORCH_CYC = 137,
   parameter int FPORCH_CYC = 38,
   parameter int N_LONG     = 10,
   parameter int N_PRE      = 10,
   parameter int N_LINES    = 304,
   parameter int N_POST     = 12,
   localparam int LINE_W    = $clog2(N_LINES)
) (
   input  logic              clk,
   input  logic              rst,
   output logic              sync_n,
   output logic              frame_trig,
   output logic              active,
   output logic [LINE_W-1:0] line_idx
);
   localparam int CNT_W = $clog2(LINE_CYC);

   generate
      if (2 * SEG_CYC >= SLOT_CYC) begin : g_bad_seg
         $error("SEG_CYC must be less than half of SLOT_CYC");
      end
      if (LINE_CYC != 2 * SLOT_CYC) begin : g_bad_line
         $error("LINE_CYC must equal two half-line slots");
      end
      if (HSYNC_CYC + BPORCH_CYC >= LINE_CYC - FPORCH_CYC) begin : g_bad_porch
         $error("line sync and porches leave no active region");
      end
      if (N_LINES < 2 || N_LONG < 1 || N_PRE < 1 || N_POST < 1) begin : g_bad_cnt
         $error("slot and line counts must be at least one, lines at least two");
      end
   endgenerate

   slot_kind_t       kind;
   logic [CNT_W-1:0] cnt;
   logic             seg_end;
   logic             frame_head;
   logic [LINE_W-1:0] line;

   cs_slot_timer #(
      .SLOT_CYC(SLOT_CYC),
      .LINE_CYC(LINE_CYC),
      .CNT_W   (CNT_W)
   ) u_timer (
      .clk    (clk),
      .rst    (rst),
      .kind   (kind),
      .cnt    (cnt),
      .seg_end(seg_end)
   );

   cs_state_seq #(
      .N_LONG (N_LONG),
      .N_PRE  (N_PRE),
      .N_LINES(N_LINES),
      .N_POST (N_POST),
      .LINE_W (LINE_W)
   ) u_seq (
      .clk       (clk),
      .rst       (rst),
      .seg_end   (seg_end),
      .kind      (kind),
      .frame_head(frame_head),
      .line      (line)
   );

   cs_wave_gen #(
      .SEG_CYC   (SEG_CYC),
      .SLOT_CYC  (SLOT_CYC),
      .LINE_CYC  (LINE_CYC),
      .HSYNC_CYC (HSYNC_CYC),
      .BPORCH_CYC(BPORCH_CYC),
      .FPORCH_CYC(FPORCH_CYC),
      .CNT_W     (CNT_W),
      .LINE_W    (LINE_W)
   ) u_wave (
      .clk       (clk),
      .rst       (rst),
      .kind      (kind),
      .cnt       (cnt),
      .frame_head(frame_head),
      .line      (line),
      .sync_n_q  (sync_n),
      .trig_q    (frame_trig),
      .active_q  (active),
      .line_q    (line_idx)
   );

   // outputs are held at their idle values on the edge after reset (R1)
   p_reset_idle_r1: assert property (@(posedge clk)
      rst |=> (sync_n && !frame_trig && !active && line_idx == '0));
endmodule

// File: tb/comp_sync_seq_bench.sv
module comp_sync_seq_bench;
   localparam int SEG   = 2;
   localparam int SLOT  = 8;
   localparam int LINE  = 16;
   localparam int HS    = 2;
   localparam int BP    = 3;
   localparam int FP    = 2;
   localparam int NL    = 2;
   localparam int NPRE  = 2;
   localparam int NLIN  = 3;
   localparam int NPOST = 3;
   localparam int LW    = $clog2(NLIN);
   localparam int PIC_START = (NL + NPRE) * SLOT;
   localparam int PIC_END   = PIC_START + NLIN * LINE;
   localparam int FRAME     = PIC_END + NPOST * SLOT;

   // columns: position, sync_n, frame_trig, active, line_idx, requirement
   localparam int NVEC = 20;
   localparam int VEC [NVEC][6] = '{
      '{0,   0, 1, 0, 0, 8},
      '{5,   0, 0, 0, 0, 2},
      '{6,   1, 0, 0, 0, 2},
      '{8,   0, 0, 0, 0, 4},
      '{16,  0, 0, 0, 0, 3},
      '{18,  1, 0, 0, 0, 3},
      '{31,  1, 0, 0, 0, 3},
      '{32,  0, 0, 0, 0, 5},
      '{34,  1, 0, 0, 0, 6},
      '{37,  1, 0, 1, 0, 6},
      '{45,  1, 0, 1, 0, 6},
      '{46,  1, 0, 0, 0, 6},
      '{48,  0, 0, 0, 1, 7},
      '{69,  1, 0, 1, 2, 7},
      '{79,  1, 0, 0, 2, 5},
      '{80,  0, 0, 0, 0, 9},
      '{82,  1, 0, 0, 0, 9},
      '{103, 1, 0, 0, 0, 4},
      '{104, 0, 1, 0, 0, 4},
      '{105, 0, 0, 0, 0, 8}
   };

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          sync_n;
   logic          frame_trig;
   logic          active;
   logic [LW-1:0] line_idx;
   int            n_checks = 0;
   int            n_fail   = 0;
   bit            done     = 1'b0;

   always #5 clk = ~clk;

   comp_sync_seq #(
      .SEG_CYC(SEG), .SLOT_CYC(SLOT), .LINE_CYC(LINE),
      .HSYNC_CYC(HS), .BPORCH_CYC(BP), .FPORCH_CYC(FP),
      .N_LONG(NL), .N_PRE(NPRE), .N_LINES(NLIN), .N_POST(NPOST)
   ) u_comp_sync_seq (
      .clk(clk), .rst(rst), .sync_n(sync_n),
      .frame_trig(frame_trig), .active(active), .line_idx(line_idx)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // expected outputs at frame position p, from the requirements
   function automatic void model(input int p, output int s, output int d,
                                 output int a, output int l, output string req);
      int q, c, r;
      q = p % FRAME;
      d = (q == 0) ? 1 : 0;
      a = 0;
      l = 0;
      if (q < NL * SLOT) begin
         c = q % SLOT; s = (c < SLOT - SEG) ? 0 : 1; req = "R2";
      end else if (q < PIC_START) begin
         c = q % SLOT; s = (c < SEG) ? 0 : 1; req = "R3";
      end else if (q < PIC_END) begin
         r = q - PIC_START; l = r / LINE; c = r % LINE;
         s = (c < HS) ? 0 : 1;
         a = (c >= HS + BP && c < LINE - FP) ? 1 : 0;
         req = "R5";
      end else begin
         c = (q - PIC_END) % SLOT; s = (c < SEG) ? 0 : 1; req = "R9";
      end
   endfunction

   task automatic sweep(input int npos, input bit use_table);
      int vi = 0;
      int trig_seen = 0;
      int s, d, a, l;
      string req;
      for (int p = 0; p < npos; p++) begin
         @(posedge clk);
         #2;
         model(p, s, d, a, l, req);
         check(req, "sync_n", int'(sync_n), s);
         check("R8", "frame_trig", int'(frame_trig), d);
         check("R6", "active", int'(active), a);
         check("R7", "line_idx", int'(line_idx), l);
         trig_seen += int'(frame_trig);
         if (use_table && vi < NVEC && VEC[vi][0] == p) begin
            string rt;
            rt = $sformatf("R%0d", VEC[vi][5]);
            check(rt, "table sync_n", int'(sync_n), VEC[vi][1]);
            check(rt, "table frame_trig", int'(frame_trig), VEC[vi][2]);
            check(rt, "table active", int'(active), VEC[vi][3]);
            check(rt, "table line_idx", int'(line_idx), VEC[vi][4]);
            vi++;
         end
      end
      if (use_table) begin
         check("R4", "table entries reached", vi, NVEC);
         check("R8", "trigger pulses", trig_seen, (npos + FRAME - 1) / FRAME);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: idle values while held in reset
      check("R1", "sync_n in reset", int'(sync_n), 1);
      check("R1", "frame_trig in reset", int'(frame_trig), 0);
      check("R1", "active in reset", int'(active), 0);
      check("R1", "line_idx in reset", int'(line_idx), 0);
      rst = 1'b0;
      sweep(2 * FRAME + 10, 1'b1);
      // R1: reset in the middle of a picture line, then restart at position 0
      repeat (30) @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      check("R1", "sync_n mid reset", int'(sync_n), 1);
      check("R1", "active mid reset", int'(active), 0);
      check("R1", "line_idx mid reset", int'(line_idx), 0);
      rst = 1'b0;
      sweep(FRAME + 2, 1'b0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog run did not finish");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule